// File: doc/BRIEF.md
# Reference Holdover State Controller

This block supervises the reference input of a disciplined timebase. It decides when the reference is lost, when the disciplining loop must be frozen, and when the reference may be trusted again. It has four states: Locked, Holdover, Reacquire and Settling. Three health indications feed it: reference present, upstream lock and a quality pass. A loss counts only after it has persisted for a programmable number of cycles. On the move from Locked into Holdover the block latches a last-known-good snapshot of the control word, temperature, source ID, timestamp and health flags. It asserts the freeze output and emits a one-cycle event with a reason code.

When the reference comes back, recovery takes two separate phases. In Reacquire, Holdover stays asserted until the inputs have been healthy for a lock window. In Settling, the loop runs again but ToSpec stays low until an external settling gate reports stability. A minimum-dwell counter gates every state change, so the machine cannot flap near a threshold. The block also counts reacquire attempts and measures how long each holdover episode lasted, in timestamp ticks. The servo, the oscillator and the log storage that consume these outputs are outside the block.

Top module: `refhold_ctrl`

## Requirements
- R1: A cycle is failing when `ref_present_i`=0, `up_lock_i`=0 or `qual_ok_i`=0. The reason code has priority in that order: absent gives 1, unlock gives 2, quality gives 3.
- R2: A loss is confirmed only at the clock edge that samples the `loss_win_i`-th consecutive failing cycle. A failure that lasts fewer cycles leaves the state unchanged.
- R3: On the move from Locked into Holdover, the snapshot outputs capture `efc_i`, `temp_i`, `src_id_i` and `tstamp_i`. They also capture `snap_flags_o` = {present, lock, quality} (bit 2 down to bit 0). The snapshot then holds until the next move out of Locked.
- R4: On entry to Holdover, `holdover_o`=1, `freeze_o`=1 and `state_o`=1 from the same edge on. The event strobe carries the R1 reason code.
- R5: At entry from Locked, `hr_alarm_o` is set on the same edge when min(`efc_i`, 2^EFC_W-1-`efc_i`) < `headroom_thr_i`. Otherwise it is cleared. It is also cleared on the return to Locked.
- R6: Holdover moves to Reacquire once the inputs are healthy. In Reacquire, `holdover_o` and `freeze_o` stay 1. Settling is entered after `lock_win_i` consecutive healthy cycles counted from entry into Reacquire, with event code 4.
- R7: In Settling, `holdover_o`=0 and `tospec_o`=0. The move to Locked happens only when `settle_ok_i`=1 with healthy inputs. It sets `tospec_o`=1 and gives event code 5.
- R8: A state entered at edge t is left no earlier than edge t+`dwell_i`+1.
- R9: `reacq_cnt_o` counts Holdover-to-Reacquire moves and clears on entry from Locked. On the Reacquire-to-Settling edge, `ho_dur_o` becomes `tstamp_i` minus the snapshot timestamp.
- R10: `state_o` is encoded Locked=0, Holdover=1, Reacquire=2, Settling=3. Synchronous reset enters Reacquire with `holdover_o`=1 and `tospec_o`=0.
- R11: A confirmed loss during Reacquire or Settling returns the machine to Holdover with a reason event. The snapshot is left untouched.
- R12: `evt_valid_o` is high for exactly the one cycle after a transition edge that carries an event, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_present_i | input | 1 | Reference signal present |
| up_lock_i | input | 1 | Upstream lock indication |
| qual_ok_i | input | 1 | Reference quality check passed |
| settle_ok_i | input | 1 | Settling/stability gate passed |
| efc_i | input | EFC_W | Current frequency-control word |
| temp_i | input | TEMP_W | Temperature word |
| src_id_i | input | SRC_W | Active reference source ID |
| tstamp_i | input | TS_W | Free-running timestamp |
| loss_win_i | input | WIN_W | Loss debounce window in cycles |
| lock_win_i | input | WIN_W | Lock-stable window in cycles |
| dwell_i | input | WIN_W | Minimum dwell per state in cycles |
| headroom_thr_i | input | EFC_W | Control-word headroom threshold |
| state_o | output | 2 | Current state code |
| holdover_o | output | 1 | Holdover flag |
| reacq_o | output | 1 | Reacquire flag |
| tospec_o | output | 1 | Output within specification |
| freeze_o | output | 1 | Freeze command to the disciplining loop |
| hr_alarm_o | output | 1 | Low headroom at entry |
| evt_valid_o | output | 1 | One-cycle event strobe |
| evt_code_o | output | 3 | Event reason code |
| snap_efc_o | output | EFC_W | Snapshot control word |
| snap_temp_o | output | TEMP_W | Snapshot temperature |
| snap_src_o | output | SRC_W | Snapshot source ID |
| snap_ts_o | output | TS_W | Snapshot timestamp |
| snap_flags_o | output | 3 | Snapshot {present, lock, quality} |
| reacq_cnt_o | output | ACNT_W | Reacquire attempts this episode |
| ho_dur_o | output | TS_W | Last holdover duration in ticks |

## Verification
The loss filter is swept with failures lasting from one cycle up to one less than the window, and each of the three causes drives one of those lengths. These runs separate a correct debounce from one that is off by a cycle. The window length itself must then enter Holdover on exactly the expected edge. Simultaneous causes show the reason priority, and two control words show the alarm boundary: one at exactly the headroom threshold and one just below it. A lock drop during Reacquire, together with a changed control word, tells a retained snapshot apart from a recaptured one. A raised dwell setting shows that Holdover is held for precisely that many extra cycles.

// File: rtl/refhold_pkg.sv
package refhold_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED   = 2'd0,
    ST_HOLDOVER = 2'd1,
    ST_REACQ    = 2'd2,
    ST_SETTLE   = 2'd3
  } hstate_e;

  localparam logic [2:0] EV_NONE   = 3'd0;
  localparam logic [2:0] EV_ABSENT = 3'd1;
  localparam logic [2:0] EV_UNLOCK = 3'd2;
  localparam logic [2:0] EV_QUAL   = 3'd3;
  localparam logic [2:0] EV_REACQ  = 3'd4;
  localparam logic [2:0] EV_TOSPEC = 3'd5;
endpackage

// File: rtl/refhold_debounce.sv
// Counts consecutive cycles of a condition; hit on the edge that samples the win-th one.
module refhold_debounce #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cond,
  input  logic [CW-1:0] win,
  output logic          hit
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    hit     = cond && (cnt_inc >= {1'b0, win});
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !cond)
      cnt_q <= '0;
    else if (cnt_q != '1)
      cnt_q <= cnt_q + 1'b1;
  end

  AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (hit && win > 1) |-> $past(cond)); // R2
endmodule

// File: rtl/refhold_snapshot.sv
// Last-known-good capture and headroom alarm.
module refhold_snapshot #(
  parameter int EFC_W  = 16,
  parameter int TEMP_W = 12,
  parameter int SRC_W  = 4,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              clr_alarm,
  input  logic [EFC_W-1:0]  efc,
  input  logic [TEMP_W-1:0] temp,
  input  logic [SRC_W-1:0]  src,
  input  logic [TS_W-1:0]   ts,
  input  logic [2:0]        flags,
  input  logic [EFC_W-1:0]  thr,
  output logic [EFC_W-1:0]  snap_efc,
  output logic [TEMP_W-1:0] snap_temp,
  output logic [SRC_W-1:0]  snap_src,
  output logic [TS_W-1:0]   snap_ts,
  output logic [2:0]        snap_flags,
  output logic              alarm
);
  localparam logic [EFC_W-1:0] EFC_MAX = '1;

  logic [EFC_W-1:0] room_hi;
  logic [EFC_W-1:0] room;
  logic             room_low;

  always_comb begin
    room_hi  = EFC_MAX - efc;
    room     = (efc < room_hi) ? efc : room_hi;
    room_low = room < thr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_efc   <= '0;
      snap_temp  <= '0;
      snap_src   <= '0;
      snap_ts    <= '0;
      snap_flags <= '0;
      alarm      <= 1'b0;
    end else begin
      if (cap) begin
        snap_efc   <= efc;
        snap_temp  <= temp;
        snap_src   <= src;
        snap_ts    <= ts;
        snap_flags <= flags;
        alarm      <= room_low;
      end else if (clr_alarm) begin
        alarm      <= 1'b0;
      end
    end
  end

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(cap) |-> ($stable(snap_efc) && $stable(snap_ts))); // R3
  AST_ALARM_AT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> $past(cap)); // R5
endmodule

// File: rtl/refhold_ctrl.sv
module refhold_ctrl
  import refhold_pkg::*;
#(
  parameter int EFC_W  = 16,
  parameter int TEMP_W = 12,
  parameter int SRC_W  = 4,
  parameter int TS_W   = 32,
  parameter int WIN_W  = 8,
  parameter int ACNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_present_i,
  input  logic              up_lock_i,
  input  logic              qual_ok_i,
  input  logic              settle_ok_i,
  input  logic [EFC_W-1:0]  efc_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [SRC_W-1:0]  src_id_i,
  input  logic [TS_W-1:0]   tstamp_i,
  input  logic [WIN_W-1:0]  loss_win_i,
  input  logic [WIN_W-1:0]  lock_win_i,
  input  logic [WIN_W-1:0]  dwell_i,
  input  logic [EFC_W-1:0]  headroom_thr_i,
  output logic [1:0]        state_o,
  output logic              holdover_o,
  output logic              reacq_o,
  output logic              tospec_o,
  output logic              freeze_o,
  output logic              hr_alarm_o,
  output logic              evt_valid_o,
  output logic [2:0]        evt_code_o,
  output logic [EFC_W-1:0]  snap_efc_o,
  output logic [TEMP_W-1:0] snap_temp_o,
  output logic [SRC_W-1:0]  snap_src_o,
  output logic [TS_W-1:0]   snap_ts_o,
  output logic [2:0]        snap_flags_o,
  output logic [ACNT_W-1:0] reacq_cnt_o,
  output logic [TS_W-1:0]   ho_dur_o
);
  hstate_e          state_q, state_d;
  logic [WIN_W-1:0] dwell_q;
  logic             dwell_ok;
  logic             fail, healthy;
  logic [2:0]       why;
  logic             loss_hit, lock_hit;
  logic             moved, cap;
  logic             ev_d;
  logic [2:0]       code_d;

  always_comb begin
    fail    = !ref_present_i || !up_lock_i || !qual_ok_i;
    healthy = !fail;
    if (!ref_present_i)  why = EV_ABSENT;
    else if (!up_lock_i) why = EV_UNLOCK;
    else                 why = EV_QUAL;
    dwell_ok = dwell_q >= dwell_i;
  end

  refhold_debounce #(.CW(WIN_W)) u_loss (
    .clk(clk), .rst(rst), .clr(moved), .cond(fail), .win(loss_win_i), .hit(loss_hit)
  );

  refhold_debounce #(.CW(WIN_W)) u_lock (
    .clk(clk), .rst(rst), .clr(moved), .cond(healthy), .win(lock_win_i), .hit(lock_hit)
  );

  always_comb begin
    state_d = state_q;
    ev_d    = 1'b0;
    code_d  = EV_NONE;
    if (dwell_ok) begin
      case (state_q)
        ST_LOCKED: if (loss_hit) begin
          state_d = ST_HOLDOVER; ev_d = 1'b1; code_d = why;
        end
        ST_HOLDOVER: if (healthy) state_d = ST_REACQ;
        ST_REACQ: begin
          if (loss_hit) begin
            state_d = ST_HOLDOVER; ev_d = 1'b1; code_d = why;
          end else if (lock_hit) begin
            state_d = ST_SETTLE; ev_d = 1'b1; code_d = EV_REACQ;
          end
        end
        ST_SETTLE: begin
          if (loss_hit) begin
            state_d = ST_HOLDOVER; ev_d = 1'b1; code_d = why;
          end else if (settle_ok_i && healthy) begin
            state_d = ST_LOCKED; ev_d = 1'b1; code_d = EV_TOSPEC;
          end
        end
        default: state_d = ST_REACQ;
      endcase
    end
    moved = state_d != state_q;
    cap   = (state_q == ST_LOCKED) && (state_d == ST_HOLDOVER);
  end

  refhold_snapshot #(.EFC_W(EFC_W), .TEMP_W(TEMP_W), .SRC_W(SRC_W), .TS_W(TS_W)) u_snap (
    .clk(clk), .rst(rst), .cap(cap), .clr_alarm(state_d == ST_LOCKED),
    .efc(efc_i), .temp(temp_i), .src(src_id_i), .ts(tstamp_i),
    .flags({ref_present_i, up_lock_i, qual_ok_i}), .thr(headroom_thr_i),
    .snap_efc(snap_efc_o), .snap_temp(snap_temp_o), .snap_src(snap_src_o),
    .snap_ts(snap_ts_o), .snap_flags(snap_flags_o), .alarm(hr_alarm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_REACQ;
      dwell_q     <= '0;
      holdover_o  <= 1'b1;
      reacq_o     <= 1'b1;
      tospec_o    <= 1'b0;
      freeze_o    <= 1'b1;
      evt_valid_o <= 1'b0;
      evt_code_o  <= EV_NONE;
      reacq_cnt_o <= '0;
      ho_dur_o    <= '0;
    end else begin
      state_q     <= state_d;
      holdover_o  <= (state_d == ST_HOLDOVER) || (state_d == ST_REACQ);
      freeze_o    <= (state_d == ST_HOLDOVER) || (state_d == ST_REACQ);
      reacq_o     <= state_d == ST_REACQ;
      tospec_o    <= state_d == ST_LOCKED;
      evt_valid_o <= ev_d;
      evt_code_o  <= code_d;
      if (moved)
        dwell_q <= '0;
      else if (dwell_q != '1)
        dwell_q <= dwell_q + 1'b1;
      if (cap)
        reacq_cnt_o <= '0;
      else if (state_q == ST_HOLDOVER && state_d == ST_REACQ && reacq_cnt_o != '1)
        reacq_cnt_o <= reacq_cnt_o + 1'b1;
      if (state_q == ST_REACQ && state_d == ST_SETTLE)
        ho_dur_o <= tstamp_i - snap_ts_o;
    end
  end

  assign state_o = state_q;

  AST_LOSS_PERSIST: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLDOVER && $past(state_q) != ST_HOLDOVER) |-> $past(fail)); // R2
  AST_ENTRY_EVENT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLDOVER && $past(state_q) != ST_HOLDOVER)
      |-> (evt_valid_o && evt_code_o >= EV_ABSENT && evt_code_o <= EV_QUAL && freeze_o)); // R4
  AST_HOLD_IN_REACQ: assert property (@(posedge clk) disable iff (rst)
    reacq_o |-> (holdover_o && freeze_o)); // R6
  AST_TOSPEC_CLEAN: assert property (@(posedge clk) disable iff (rst)
    tospec_o |-> (!holdover_o && !reacq_o)); // R7
  AST_TOSPEC_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(tospec_o) |-> $past(settle_ok_i)); // R7
  AST_DWELL_MIN: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q)) |-> ($past(dwell_q) >= $past(dwell_i))); // R8
endmodule

// File: tb/refhold_ctrl_bench.sv
module refhold_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        ref_present_i, up_lock_i, qual_ok_i, settle_ok_i;
  logic [15:0] efc_i;
  logic [11:0] temp_i;
  logic [3:0]  src_id_i;
  logic [31:0] tstamp_i;
  logic [7:0]  loss_win_i, lock_win_i, dwell_i;
  logic [15:0] headroom_thr_i;
  logic [1:0]  state_o;
  logic        holdover_o, reacq_o, tospec_o, freeze_o, hr_alarm_o, evt_valid_o;
  logic [2:0]  evt_code_o;
  logic [15:0] snap_efc_o;
  logic [11:0] snap_temp_o;
  logic [3:0]  snap_src_o;
  logic [31:0] snap_ts_o;
  logic [2:0]  snap_flags_o;
  logic [7:0]  reacq_cnt_o;
  logic [31:0] ho_dur_o;

  int n_chk = 0;
  int n_fail = 0;
  int tick = 0;
  bit done = 0;
  logic [31:0] exp_ts, exp_dur;

  always #2 clk = ~clk;

  refhold_ctrl u_refhold_ctrl (
    .clk(clk), .rst(rst), .ref_present_i(ref_present_i), .up_lock_i(up_lock_i),
    .qual_ok_i(qual_ok_i), .settle_ok_i(settle_ok_i), .efc_i(efc_i), .temp_i(temp_i),
    .src_id_i(src_id_i), .tstamp_i(tstamp_i), .loss_win_i(loss_win_i),
    .lock_win_i(lock_win_i), .dwell_i(dwell_i), .headroom_thr_i(headroom_thr_i),
    .state_o(state_o), .holdover_o(holdover_o), .reacq_o(reacq_o), .tospec_o(tospec_o),
    .freeze_o(freeze_o), .hr_alarm_o(hr_alarm_o), .evt_valid_o(evt_valid_o),
    .evt_code_o(evt_code_o), .snap_efc_o(snap_efc_o), .snap_temp_o(snap_temp_o),
    .snap_src_o(snap_src_o), .snap_ts_o(snap_ts_o), .snap_flags_o(snap_flags_o),
    .reacq_cnt_o(reacq_cnt_o), .ho_dur_o(ho_dur_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
    tick++;
    tstamp_i = tick;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic healthy_in();
    ref_present_i = 1; up_lock_i = 1; qual_ok_i = 1;
  endtask

  // Holdover -> Reacquire -> Settling -> Locked with dwell 2, lock window 3, settle_ok high
  task automatic recover();
    healthy_in();
    settle_ok_i = 1;
    for (int i = 0; i < 9; i++) step();
    chk("R7 recovered to Locked", state_o, 0);
    chk("R5 alarm cleared in Locked", hr_alarm_o, 0);
  endtask

  initial begin
    rst = 1; healthy_in(); settle_ok_i = 0;
    efc_i = 16'h1234; temp_i = 12'h3A5; src_id_i = 4'h9; tstamp_i = 0;
    loss_win_i = 4; lock_win_i = 3; dwell_i = 2; headroom_thr_i = 16'd100;
    step(); step(); step();
    rst = 0;
    chk("R10 reset state Reacquire", state_o, 2);
    chk("R10 reset holdover", holdover_o, 1);
    chk("R10 reset tospec", tospec_o, 0);
    chk("R10 reset freeze", freeze_o, 1);
    chk("R12 reset no event", evt_valid_o, 0);
    chk("R9 reset attempt count", reacq_cnt_o, 0);

    step(); step();
    chk("R6 still Reacquire before window", state_o, 2);
    chk("R6 holdover kept in Reacquire", holdover_o, 1);
    step();
    chk("R6 Settling after lock window", state_o, 3);
    chk("R6 reacquired event", {evt_valid_o, evt_code_o}, {1'b1, 3'd4});
    chk("R7 holdover low in Settling", holdover_o, 0);
    step();
    chk("R12 strobe one cycle", evt_valid_o, 0);
    step(); step(); step();
    chk("R7 tospec low without gate", tospec_o, 0);
    chk("R7 stays Settling", state_o, 3);
    settle_ok_i = 1;
    step();
    chk("R7 Locked after gate", state_o, 0);
    chk("R7 tospec set", tospec_o, 1);
    chk("R7 to-spec event", {evt_valid_o, evt_code_o}, {1'b1, 3'd5});

    // R2 glitch sweep: each cause, lengths 1..window-1
    for (int g = 1; g < 4; g++) begin
      if (g == 1) ref_present_i = 0;
      else if (g == 2) up_lock_i = 0;
      else qual_ok_i = 0;
      for (int i = 0; i < g; i++) begin
        step();
        chk("R2 glitch ignored", holdover_o, 0);
      end
      healthy_in();
      step();
      chk("R2 still Locked after glitch", state_o, 0);
    end

    // full-length loss, cause absent
    ref_present_i = 0;
    step(); step(); step();
    chk("R2 no entry before window", holdover_o, 0);
    exp_ts = tick;
    step();
    chk("R4 holdover on entry", holdover_o, 1);
    chk("R4 freeze on entry", freeze_o, 1);
    chk("R4 state Holdover", state_o, 1);
    chk("R1 absent reason", {evt_valid_o, evt_code_o}, {1'b1, 3'd1});
    chk("R3 snapshot efc", snap_efc_o, 16'h1234);
    chk("R3 snapshot temp", snap_temp_o, 12'h3A5);
    chk("R3 snapshot src", snap_src_o, 4'h9);
    chk("R3 snapshot ts", snap_ts_o, exp_ts);
    chk("R3 snapshot flags", snap_flags_o, 3'b011);
    chk("R5 no alarm mid-range", hr_alarm_o, 0);

    // R8 longer dwell in Holdover
    dwell_i = 6; ref_present_i = 1; efc_i = 16'h0F0F;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R8 held by dwell", state_o, 1);
    end
    chk("R3 snapshot not retaken", snap_efc_o, 16'h1234);
    step();
    chk("R8 leaves after dwell", state_o, 2);
    chk("R9 first attempt", reacq_cnt_o, 1);
    dwell_i = 2;

    // R11 lock drop in Reacquire
    up_lock_i = 0; settle_ok_i = 0;
    step(); step(); step();
    chk("R11 Reacquire before window", state_o, 2);
    step();
    chk("R11 back to Holdover", state_o, 1);
    chk("R11 unlock event", {evt_valid_o, evt_code_o}, {1'b1, 3'd2});
    chk("R11 snapshot kept", snap_efc_o, 16'h1234);
    up_lock_i = 1;
    step(); step();
    chk("R8 Holdover dwell", state_o, 1);
    step();
    chk("R9 second attempt", reacq_cnt_o, 2);
    step(); step();
    chk("R6 holdover during Reacquire", holdover_o, 1);
    exp_dur = tick - exp_ts;
    step();
    chk("R6 Settling", state_o, 3);
    chk("R9 holdover duration", ho_dur_o, exp_dur);
    step(); step(); step();
    chk("R7 tospec waits for gate", tospec_o, 0);
    settle_ok_i = 1;
    step();
    chk("R7 Locked", tospec_o, 1);

    // quality loss near rail
    efc_i = 16'hFFC0; qual_ok_i = 0;
    step(); step(); step(); step();
    chk("R1 quality reason", {evt_valid_o, evt_code_o}, {1'b1, 3'd3});
    chk("R5 alarm near upper rail", hr_alarm_o, 1);
    chk("R3 flags quality fail", snap_flags_o, 3'b110);
    chk("R9 attempts cleared", reacq_cnt_o, 0);
    recover();

    // priority unlock over quality, headroom exactly at threshold
    efc_i = 16'd100; up_lock_i = 0; qual_ok_i = 0;
    step(); step(); step(); step();
    chk("R1 unlock beats quality", evt_code_o, 2);
    chk("R5 no alarm at threshold", hr_alarm_o, 0);
    recover();

    // priority absent over unlock, headroom one below threshold
    efc_i = 16'd99; ref_present_i = 0; up_lock_i = 0;
    step(); step(); step(); step();
    chk("R1 absent beats unlock", evt_code_o, 1);
    chk("R5 alarm below threshold", hr_alarm_o, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule